// File: doc/BRIEF.md
# Synchronous FIFO with Read Bookmark and Preset Level Flags

A single-clock FIFO of 64 words by 20 bits, with a registered read output. At master reset it picks one of two read styles. In standard style, a word reaches the output register only when a read is requested. In fall-through style, the oldest word moves into the output register on its own. The same reset also picks one of four preset threshold pairs for the two level flags. Two status outputs change meaning with the style. The first reports empty, or output data ready. The second reports full, or write space available.

The read position can be bookmarked with a mark pulse and later rewound to the bookmark with a rewind pulse. This replays the words read since the mark without writing them again. A partial reset empties the FIFO but keeps the style and thresholds chosen at the last master reset.

Top module: `fifo_mr`

## Requirements
- R1: While `rst_ni` is low, the block samples `fwft_mode_i` and `preset_sel_i`, and clears `rd_data_o` to 0. After release the FIFO is empty: `empty_ready_o`=1 in standard style and 0 in fall-through style, `almost_empty_o`=0, `almost_full_o`=1.
- R2: The word count is the number of words held in storage. A word in the output register is not counted. In standard style (`fwft_mode_i`=0), `empty_ready_o` is 1 exactly when the count is 0, and `full_ready_o` is 1 exactly when the count is 64.
- R3: A write while the count is 64 is dropped. A read request while the count is 0 leaves `rd_data_o` unchanged.
- R4: In standard style, a read request accepted at a clock edge puts the oldest stored word on `rd_data_o` after that edge. Words leave in write order. Without a read request, `rd_data_o` holds its value.
- R5: In fall-through style (`fwft_mode_i`=1), a written word is loaded into the output register one edge after it is stored, with no read request, and `empty_ready_o` goes to 1. `full_ready_o` is 1 exactly when the count is below 64.
- R6: In fall-through style, a read request consumes the output word and reloads the next stored word. If storage is empty, `empty_ready_o` falls to 0.
- R7: `almost_empty_o` is 1 when the count is at least n, and 0 when it is below n.
- R8: `almost_full_o` is 1 when 64 minus the count is greater than m, and 0 otherwise.
- R9: `preset_sel_i` values 0, 1, 2 and 3 select (n, m) = (1,1), (4,4), (8,8) and (16,16).
- R10: A pulse on `mark_i` stores the current read position. Each new mark replaces the previous one, and both resets return the mark to position 0.
- R11: A pulse on `rewind_i` sets the read position to the stored mark and recomputes the count from it. A read request in the same cycle is ignored.
- R12: `part_rst_i` (synchronous, active high) clears the pointers, the mark and the output register, but keeps the style and thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| part_rst_i | input | 1 | Synchronous partial reset |
| fwft_mode_i | input | 1 | Style select, sampled during master reset (1 = fall-through) |
| preset_sel_i | input | 2 | Threshold preset select, sampled during master reset |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | 20 | Write data |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | 20 | Registered read data |
| mark_i | input | 1 | Bookmark the read position |
| rewind_i | input | 1 | Restore the read position to the bookmark |
| empty_ready_o | output | 1 | Empty (standard) / output ready (fall-through) |
| full_ready_o | output | 1 | Full (standard) / space available (fall-through) |
| almost_empty_o | output | 1 | Count at least n |
| almost_full_o | output | 1 | Free space greater than m |

## Verification
The assertions check on every cycle that:
- the count never exceeds the depth;
- an accepted write never meets a full store, and an accepted read never meets an empty one;
- mark and rewind move the bookmark and the read pointer exactly one edge later;
- partial reset empties the store;
- the standard-style output holds without a read;
- a ready fall-through word stays ready until it is consumed.

Only the bench scenarios can show that:
- data comes out in order, including after a rewind;
- the flag thresholds follow each preset;
- the style survives a partial reset;
- a dropped write never appears at the output.

// File: rtl/fifo_mr_pkg.sv
package fifo_mr_pkg;

  typedef struct packed {
    logic       fwft;
    logic [1:0] sel;
  } fifo_cfg_t;

  // preset offsets: 1, 4, 8, 16
  function automatic int unsigned preset_off(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (32'd2 << s);
  endfunction

endpackage

// File: rtl/fifo_mr_cfg.sv
module fifo_mr_cfg
  import fifo_mr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fwft_mode_i,
  input  logic [1:0] preset_sel_i,
  output fifo_cfg_t  cfg_o
);

  fifo_cfg_t cfg_q;

  // loaded only while master reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.fwft <= fwft_mode_i;
      cfg_q.sel  <= preset_sel_i;
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/fifo_mr_ptrs.sv
module fifo_mr_ptrs #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          part_rst_i,
  input  logic          wr_go_i,
  input  logic          rd_go_i,
  input  logic          mark_i,
  input  logic          rewind_i,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // extra wrap bit; DEPTH must be a power of two
  logic [CW-1:0] wp_q, rp_q, mk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
      mk_q <= '0;
    end else if (part_rst_i) begin
      wp_q <= '0;
      rp_q <= '0;
      mk_q <= '0;
    end else begin
      if (wr_go_i) wp_q <= wp_q + 1'b1;
      if (rewind_i)     rp_q <= mk_q;
      else if (rd_go_i) rp_q <= rp_q + 1'b1;
      if (mark_i) mk_q <= rp_q;
    end
  end

  assign waddr_o = wp_q[AW-1:0];
  assign raddr_o = rp_q[AW-1:0];
  assign cnt_o   = wp_q - rp_q;

  p_count_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= FULL_CNT);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go_i |-> cnt_o != FULL_CNT);
  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_go_i |-> cnt_o != '0);
  p_mark_latest_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_i && !part_rst_i) |=> mk_q == $past(rp_q));
  p_rewind_restore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rewind_i && !part_rst_i) |=> rp_q == $past(mk_q));
  p_part_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    part_rst_i |=> cnt_o == '0);

endmodule

// File: rtl/fifo_mr_mem.sv
module fifo_mr_mem #(
  parameter int unsigned DATA_W = 20,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/fifo_mr_flags.sv
module fifo_mr_flags #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          fwft_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          out_vld_i,
  input  logic [CW-1:0] ae_thr_i,
  input  logic [CW-1:0] af_thr_i,
  output logic          empty_ready_o,
  output logic          full_ready_o,
  output logic          almost_empty_o,
  output logic          almost_full_o
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] free_cnt;

  assign free_cnt       = FULL_CNT - cnt_i;
  assign empty_ready_o  = fwft_i ? out_vld_i : (cnt_i == '0);
  assign full_ready_o   = fwft_i ? (cnt_i != FULL_CNT) : (cnt_i == FULL_CNT);
  assign almost_empty_o = cnt_i >= ae_thr_i;
  assign almost_full_o  = free_cnt > af_thr_i;

endmodule

// File: rtl/fifo_mr.sv
module fifo_mr
  import fifo_mr_pkg::*;
#(
  parameter int unsigned DATA_W = 20,
  parameter int unsigned DEPTH  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              part_rst_i,
  input  logic              fwft_mode_i,
  input  logic [1:0]        preset_sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              mark_i,
  input  logic              rewind_i,
  output logic              empty_ready_o,
  output logic              full_ready_o,
  output logic              almost_empty_o,
  output logic              almost_full_o
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  fifo_cfg_t         cfg;
  logic [AW-1:0]     waddr, raddr;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     ae_thr, af_thr;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] dout_q;
  logic              vld_q;
  logic              wr_go, rd_go, std_rd, fwft_load, mem_has;

  fifo_mr_cfg u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fwft_mode_i  (fwft_mode_i),
    .preset_sel_i (preset_sel_i),
    .cfg_o        (cfg)
  );

  assign ae_thr = CW'(preset_off(cfg.sel));
  assign af_thr = CW'(preset_off(cfg.sel));

  assign mem_has   = cnt != '0;
  assign wr_go     = wr_en_i && (cnt != FULL_CNT);
  assign std_rd    = !cfg.fwft && rd_en_i && mem_has && !rewind_i;
  assign fwft_load = cfg.fwft && mem_has && !rewind_i && (!vld_q || rd_en_i);
  assign rd_go     = cfg.fwft ? fwft_load : std_rd;

  fifo_mr_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .part_rst_i (part_rst_i),
    .wr_go_i    (wr_go),
    .rd_go_i    (rd_go),
    .mark_i     (mark_i),
    .rewind_i   (rewind_i),
    .waddr_o    (waddr),
    .raddr_o    (raddr),
    .cnt_o      (cnt)
  );

  fifo_mr_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_go),
    .waddr_i (waddr),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      vld_q  <= 1'b0;
    end else if (part_rst_i) begin
      dout_q <= '0;
      vld_q  <= 1'b0;
    end else if (cfg.fwft) begin
      // a rewind drops the held word so the marked word reloads
      if (rewind_i) begin
        vld_q <= 1'b0;
      end else if (fwft_load) begin
        dout_q <= mem_rdata;
        vld_q  <= 1'b1;
      end else if (rd_en_i && vld_q) begin
        vld_q <= 1'b0;
      end
    end else if (std_rd) begin
      dout_q <= mem_rdata;
    end
  end

  assign rd_data_o = dout_q;

  fifo_mr_flags #(.DEPTH(DEPTH)) u_flags (
    .fwft_i         (cfg.fwft),
    .cnt_i          (cnt),
    .out_vld_i      (vld_q),
    .ae_thr_i       (ae_thr),
    .af_thr_i       (af_thr),
    .empty_ready_o  (empty_ready_o),
    .full_ready_o   (full_ready_o),
    .almost_empty_o (almost_empty_o),
    .almost_full_o  (almost_full_o)
  );

  p_std_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg.fwft && !rd_en_i && !part_rst_i) |=> $stable(rd_data_o));
  p_ready_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.fwft && vld_q && !rd_en_i && !rewind_i && !part_rst_i) |=> empty_ready_o);

endmodule

// File: tb/fifo_mr_tb_top.sv
module fifo_mr_tb_top;

  localparam int DW = 20;
  localparam int DEPTH = 64;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          part_rst = 1'b0;
  logic          fwft_mode = 1'b0;
  logic [1:0]    preset_sel = 2'd0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          mark = 1'b0;
  logic          rewind = 1'b0;
  logic          empty_ready, full_ready, almost_empty, almost_full;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fifo_mr dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .part_rst_i     (part_rst),
    .fwft_mode_i    (fwft_mode),
    .preset_sel_i   (preset_sel),
    .wr_en_i        (wr_en),
    .wr_data_i      (wr_data),
    .rd_en_i        (rd_en),
    .rd_data_o      (rd_data),
    .mark_i         (mark),
    .rewind_i       (rewind),
    .empty_ready_o  (empty_ready),
    .full_ready_o   (full_ready),
    .almost_empty_o (almost_empty),
    .almost_full_o  (almost_full)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic mreset(input logic fw, input logic [1:0] sel);
    @(negedge clk);
    rst_ni = 1'b0;
    fwft_mode = fw;
    preset_sel = sel;
    wr_en = 0; rd_en = 0; mark = 0; rewind = 0; part_rst = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    fwft_mode = ~fw;
    preset_sel = ~sel;
    @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop_chk(input string req, input logic [DW-1:0] exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic t_reset;
    mreset(1'b0, 2'd0);
    chk("R1 rd_data", 32'(rd_data), 0);
    chk("R1 empty", 32'(empty_ready), 1);
    chk("R1 full", 32'(full_ready), 0);
    chk("R1 almost_empty", 32'(almost_empty), 0);
    chk("R1 almost_full", 32'(almost_full), 1);
  endtask

  task automatic t_std_fill;
    mreset(1'b0, 2'd0);
    for (int i = 0; i < DEPTH; i++) push(DW'(i * 3 + 5));
    chk("R2 full at 64", 32'(full_ready), 1);
    chk("R2 not empty", 32'(empty_ready), 0);
    push(20'hABCDE);
    chk("R3 full after drop", 32'(full_ready), 1);
    for (int i = 0; i < DEPTH; i++) pop_chk("R4 order", DW'(i * 3 + 5));
    chk("R2 empty after drain", 32'(empty_ready), 1);
    pop_chk("R3 read when empty ignored", DW'((DEPTH - 1) * 3 + 5));
    repeat (2) @(negedge clk);
    chk("R4 hold without read", 32'(rd_data), 32'((DEPTH - 1) * 3 + 5));
  endtask

  task automatic t_thresholds;
    for (int s = 0; s < 4; s++) begin
      int n;
      n = (s == 0) ? 1 : (2 << s);
      mreset(1'b0, 2'(s));
      for (int i = 0; i < n - 1; i++) push(DW'(i));
      chk("R7 R9 below n", 32'(almost_empty), 0);
      push(20'h1);
      chk("R7 R9 at n", 32'(almost_empty), 1);
      for (int i = n; i < DEPTH - n - 1; i++) push(DW'(i));
      chk("R8 R9 free m+1", 32'(almost_full), 1);
      push(20'h2);
      chk("R8 R9 free m", 32'(almost_full), 0);
    end
  endtask

  task automatic t_fwft;
    mreset(1'b1, 2'd0);
    chk("R1 fwft not ready", 32'(empty_ready), 0);
    chk("R5 space", 32'(full_ready), 1);
    push(20'h0AAAA); push(20'h0BBBB); push(20'h0CCCC);
    chk("R5 falls through", 32'(rd_data), 32'h0AAAA);
    chk("R5 ready", 32'(empty_ready), 1);
    pop_chk("R6 next word", 20'h0BBBB);
    pop_chk("R6 last word", 20'h0CCCC);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R6 ready drops", 32'(empty_ready), 0);
    mreset(1'b1, 2'd0);
    for (int i = 0; i < DEPTH + 1; i++) push(DW'(i + 16));
    chk("R5 no space", 32'(full_ready), 0);
    push(20'hFFFFF);
    pop_chk("R6 after full", DW'(17));
    chk("R5 space again", 32'(full_ready), 1);
  endtask

  task automatic t_mark;
    mreset(1'b0, 2'd1);
    for (int i = 0; i < 10; i++) push(DW'(100 + i));
    for (int i = 0; i < 3; i++) pop_chk("R4 pre-mark", DW'(100 + i));
    mark = 1'b1; @(negedge clk); mark = 1'b0;
    for (int i = 3; i < 5; i++) pop_chk("R4 between marks", DW'(100 + i));
    mark = 1'b1; @(negedge clk); mark = 1'b0;
    for (int i = 5; i < 7; i++) pop_chk("R4 after mark", DW'(100 + i));
    chk("R7 count 3", 32'(almost_empty), 0);
    rewind = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    rewind = 1'b0; rd_en = 1'b0;
    chk("R11 read ignored on rewind", 32'(rd_data), 106);
    chk("R11 count recomputed", 32'(almost_empty), 1);
    pop_chk("R10 latest mark replayed", DW'(105));
  endtask

  task automatic t_partial;
    mreset(1'b0, 2'd2);
    for (int i = 0; i < 5; i++) push(DW'(200 + i));
    pop_chk("R4 before partial", DW'(200));
    part_rst = 1'b1; @(negedge clk); part_rst = 1'b0;
    chk("R12 output cleared", 32'(rd_data), 0);
    chk("R12 empty", 32'(empty_ready), 1);
    chk("R12 almost_empty", 32'(almost_empty), 0);
    for (int i = 0; i < 8; i++) push(DW'(300 + i));
    chk("R12 n kept", 32'(almost_empty), 1);
    chk("R12 style kept", 32'(rd_data), 0);
    rewind = 1'b1; @(negedge clk); rewind = 1'b0;
    pop_chk("R10 mark cleared", DW'(300));
  endtask

  initial begin
    t_reset();
    t_std_fill();
    t_thresholds();
    t_fwft();
    t_mark();
    t_partial();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule